// File: doc/BRIEF.md
# Toggle-on-write interrupt status controller

This block collects one-cycle change events from up to two input channels and turns them into a single active-high interrupt request. Each channel owns a sticky status bit that is set by its event strobe. Software reaches three small registers over a plain register bus with address, write strobe, write data and combinational read data. The registers are a master enable, a per-channel mask and the per-channel status.

Writing a one to a status bit inverts it. A service routine can therefore acknowledge a pending channel, and a test routine can force one pending, with the same single write. Writing zero to a status bit leaves it alone. The interrupt request is registered. It is high when the master enable is set and at least one pending status bit has its mask bit set.

The `DUAL` parameter selects one or two channels. With one channel, every channel-2 bit is absent: it reads as zero and ignores writes and events.

Top module: `irqc_tow_ctrl`

## Requirements
- R1: After reset the master enable, both mask bits and both status bits are 0. `irq_o` is low, and every register reads as zero.
- R2: The master enable is a read/write bit in bit 31 of the word at offset 0x11C. Bits 30..0 of that word read as zero, and a write with bit 31 low clears the enable.
- R3: The mask register is at offset 0x128. Bit 0 belongs to channel 1 and bit 1 to channel 2, and both are read/write. Bits 31..2 read as zero even after a write of all ones.
- R4: The status register is at offset 0x120, with the same bit positions as the mask. Writing 1 to a bit inverts it and writing 0 leaves it unchanged, so one write can clear some bits and set others.
- R5: A high `evt_i[c]` in a cycle sets status bit c at that clock edge, whatever the mask and master enable hold.
- R6: If an event and a toggling write hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq_o` equals (master enable AND the OR over c of status[c] AND mask[c]) taken from the register state of the previous cycle. It therefore changes one clock after that state changes.
- R8: With `DUAL`=0, bit 1 of the mask and of the status reads as zero, writes to it are ignored, and `evt_i[1]` has no effect.
- R9: A read from any other offset returns zero, and a write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 2 | One-cycle change event per channel; bit 0 is channel 1 |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The bench goes after the toggle write with mixed ones and zeros. A design that used clear-on-write would fail to set the forced bit, and one that cleared unwritten bits would lose a pending channel. It drives an event and a toggle into the same bit in one cycle, where the wrong priority leaves the bit cleared. It checks that events are recorded while masked, so a design that gated capture with the mask would miss them. It samples `irq_o` on the first edge after the enabling write, where a combinational output would already be high one cycle early. A second instance with one channel confirms that channel-2 writes and events leave nothing behind.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [11:0] OFS_GIE = 12'h11C;
  localparam logic [11:0] OFS_ISR = 12'h120;
  localparam logic [11:0] OFS_IER = 12'h128;
  localparam int          MAX_CH  = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_GIE,
    SEL_ISR,
    SEL_IER
  } reg_sel_e;
endpackage

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_gie,
  input  logic              wr_ier,
  input  logic [DATA_W-1:0] wdata,
  output logic              gie_q,
  output logic [NUM_CH-1:0] ier_q
);
  localparam int GIE_BIT = DATA_W - 1;

  logic              gie_d;
  logic [NUM_CH-1:0] ier_d;

  always_comb begin
    gie_d = gie_q;
    ier_d = ier_q;
    if (wr_gie) gie_d = wdata[GIE_BIT];
    if (wr_ier) ier_d = wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ier_q <= '0;
    end else begin
      if (wr_gie) gie_q <= gie_d;
      if (wr_ier) ier_q <= ier_d;
    end
  end

  AST_GIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gie |=> $stable(gie_q)); // R9
  AST_IER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ier |=> $stable(ier_q)); // R9
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              tow_we,
  input  logic [NUM_CH-1:0] tow_mask,
  output logic [NUM_CH-1:0] st_q
);
  logic [NUM_CH-1:0] st_d;
  logic [NUM_CH-1:0] flip;

  always_comb begin
    flip = tow_mask & {NUM_CH{tow_we}};
    for (int c = 0; c < NUM_CH; c++) begin
      if (evt[c])       st_d[c] = 1'b1;
      else if (flip[c]) st_d[c] = ~st_q[c];
      else              st_d[c] = st_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[c] |=> st_q[c]); // R6
    AST_TOW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (tow_we && tow_mask[c] && !evt[c]) |=> (st_q[c] != $past(st_q[c]))); // R4
    AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[c] && !(tow_we && tow_mask[c])) |=> $stable(st_q[c])); // R4
  end
endmodule

// File: rtl/irqc_irq_gen.sv
module irqc_irq_gen #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic [NUM_CH-1:0] ier,
  input  logic [NUM_CH-1:0] isr,
  output logic              irq_o
);
  logic pend;
  logic irq_d;

  always_comb begin
    pend  = |(isr & ier);
    irq_d = gie & pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq_o); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ier) == '0) |=> !irq_o); // R7
  AST_IRQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && ((isr & ier) != '0)) |=> irq_o); // R7
endmodule

// File: rtl/irqc_tow_ctrl.sv
module irqc_tow_ctrl
  import irqc_pkg::*;
#(
  parameter int DUAL   = 1,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int NUM_CH = (DUAL != 0) ? 2 : 1;

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  reg_sel_e          sel;
  logic              wr_gie, wr_ier, wr_isr;
  logic              gie_q;
  logic [NUM_CH-1:0] ier_q, isr_q;
  logic [DATA_W-1:0] gie_word, ier_word, isr_word;
  logic              unused_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr == OFS_GIE[ADDR_W-1:0]) sel = SEL_GIE;
    if (reg_addr == OFS_ISR[ADDR_W-1:0]) sel = SEL_ISR;
    if (reg_addr == OFS_IER[ADDR_W-1:0]) sel = SEL_IER;
    wr_gie = reg_we && (sel == SEL_GIE);
    wr_isr = reg_we && (sel == SEL_ISR);
    wr_ier = reg_we && (sel == SEL_IER);
  end

  irqc_enable_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_en (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_gie (wr_gie),
    .wr_ier (wr_ier),
    .wdata  (reg_wdata),
    .gie_q  (gie_q),
    .ier_q  (ier_q)
  );

  irqc_status_bank #(.NUM_CH(NUM_CH)) u_st (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .evt      (evt_i[NUM_CH-1:0]),
    .tow_we   (wr_isr),
    .tow_mask (reg_wdata[NUM_CH-1:0]),
    .st_q     (isr_q)
  );

  irqc_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
    .clk   (clk),
    .rst_n (rst_q_n),
    .gie   (gie_q),
    .ier   (ier_q),
    .isr   (isr_q),
    .irq_o (irq_o)
  );

  always_comb begin
    gie_word           = '0;
    gie_word[DATA_W-1] = gie_q;
    ier_word           = '0;
    ier_word[NUM_CH-1:0] = ier_q;
    isr_word           = '0;
    isr_word[NUM_CH-1:0] = isr_q;
    unique case (sel)
      SEL_GIE: reg_rdata = gie_word;
      SEL_ISR: reg_rdata = isr_word;
      SEL_IER: reg_rdata = ier_word;
      default: reg_rdata = '0;
    endcase
  end

  assign unused_in = ^{reg_wdata, evt_i};

  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel == SEL_NONE) |-> (reg_rdata == '0)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_q_n |=> !irq_o); // R1
endmodule

// File: tb/irqc_tow_ctrl_tb.sv
`timescale 1ns/100ps
module irqc_tow_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  evt, s_evt;
  logic [8:0]  addr, s_addr;
  logic        we, s_we;
  logic [31:0] wdata, s_wdata, rdata, s_rdata;
  logic        irq, s_irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irqc_tow_ctrl #(.DUAL(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  irqc_tow_ctrl #(.DUAL(0)) u_dut_single (
    .clk(clk), .rst_n(rst_n), .evt_i(s_evt), .reg_addr(s_addr), .reg_we(s_we),
    .reg_wdata(s_wdata), .reg_rdata(s_rdata), .irq_o(s_irq));

  typedef struct packed {
    logic        we;
    logic [8:0]  addr;
    logic [31:0] wd;
    logic [1:0]  evt;
    logic [1:0]  st;
    logic [1:0]  en;
    logic        gie;
    logic        irq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 9'h128, 32'h0000_0003, 2'b00, 2'b00, 2'b11, 1'b0, 1'b0}, // R3
    '{1'b0, 9'h000, 32'h0000_0000, 2'b01, 2'b01, 2'b11, 1'b0, 1'b0}, // R5
    '{1'b1, 9'h11C, 32'h8000_0000, 2'b00, 2'b01, 2'b11, 1'b1, 1'b1}, // R2 R7
    '{1'b1, 9'h120, 32'h0000_0001, 2'b00, 2'b00, 2'b11, 1'b1, 1'b0}, // R4 clear
    '{1'b1, 9'h120, 32'h0000_0003, 2'b00, 2'b11, 2'b11, 1'b1, 1'b1}, // R4 force
    '{1'b1, 9'h128, 32'h0000_0001, 2'b00, 2'b11, 2'b01, 1'b1, 1'b1}, // R3
    '{1'b1, 9'h120, 32'h0000_0001, 2'b00, 2'b10, 2'b01, 1'b1, 1'b0}, // R7 masked
    '{1'b1, 9'h128, 32'h0000_0002, 2'b00, 2'b10, 2'b10, 1'b1, 1'b1}, // R7
    '{1'b1, 9'h11C, 32'h0000_0000, 2'b00, 2'b10, 2'b10, 1'b0, 1'b0}, // R2
    '{1'b1, 9'h11C, 32'h8000_0000, 2'b01, 2'b11, 2'b10, 1'b1, 1'b1}, // R5
    '{1'b1, 9'h120, 32'h0000_0003, 2'b01, 2'b01, 2'b10, 1'b1, 1'b0}, // R6
    '{1'b1, 9'h124, 32'hFFFF_FFFF, 2'b00, 2'b01, 2'b10, 1'b1, 1'b0}, // R9
    '{1'b1, 9'h128, 32'hFFFF_FFFF, 2'b00, 2'b01, 2'b11, 1'b1, 1'b1}, // R3
    '{1'b1, 9'h11C, 32'h7FFF_FFFF, 2'b00, 2'b01, 2'b11, 1'b0, 1'b0}, // R2
    '{1'b0, 9'h000, 32'h0000_0000, 2'b10, 2'b11, 2'b11, 1'b0, 1'b0}, // R5
    '{1'b1, 9'h128, 32'h0000_0000, 2'b00, 2'b11, 2'b00, 1'b0, 1'b0}, // R3
    '{1'b1, 9'h120, 32'h0000_0003, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0}, // R4
    '{1'b0, 9'h000, 32'h0000_0000, 2'b11, 2'b11, 2'b00, 1'b0, 1'b0}  // R5 masked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic srd(input logic [8:0] a, output logic [31:0] d);
    s_addr = a;
    #0.5;
    d = s_rdata;
  endtask

  task automatic swr(input logic [8:0] a, input logic [31:0] d, input logic [1:0] e);
    @(negedge clk);
    s_we = 1'b1; s_addr = a; s_wdata = d; s_evt = e;
    @(negedge clk);
    s_we = 1'b0; s_evt = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; evt = '0; addr = '0; we = 1'b0; wdata = '0;
    s_evt = '0; s_addr = '0; s_we = 1'b0; s_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R9 unmapped read
    rd(9'h11C, d); chk("R1 gie", d, 32'h0);
    rd(9'h120, d); chk("R1 status", d, 32'h0);
    rd(9'h128, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(9'h124, d); chk("R9 unmapped read", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VEC[i].we; addr = VEC[i].addr; wdata = VEC[i].wd; evt = VEC[i].evt;
      @(negedge clk);
      we = 1'b0; evt = 2'b00;
      @(negedge clk);
      rd(9'h11C, d); chk($sformatf("R2 gie vec%0d", i), d, {VEC[i].gie, 31'b0});
      rd(9'h120, d); chk($sformatf("R4 status vec%0d", i), d, {30'b0, VEC[i].st});
      rd(9'h128, d); chk($sformatf("R3 mask vec%0d", i), d, {30'b0, VEC[i].en});
      chk($sformatf("R7 irq vec%0d", i), {31'b0, irq}, {31'b0, VEC[i].irq});
    end

    // R7 latency: state st11 en00 gie0; set gie, then unmask and watch the edge
    @(negedge clk); we = 1'b1; addr = 9'h11C; wdata = 32'h8000_0000;
    @(negedge clk); we = 1'b0;
    @(negedge clk); chk("R7 gie alone masked", {31'b0, irq}, 32'h0);
    we = 1'b1; addr = 9'h128; wdata = 32'h1;
    @(posedge clk); #1; we = 1'b0;
    chk("R7 irq not yet on state edge", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    chk("R7 irq one edge later", {31'b0, irq}, 32'h1);

    // R8 single-channel instance
    swr(9'h128, 32'h3, 2'b00);
    srd(9'h128, d); chk("R8 single mask", d, 32'h1);
    swr(9'h120, 32'h3, 2'b00);
    srd(9'h120, d); chk("R8 single status force", d, 32'h1);
    swr(9'h120, 32'h1, 2'b00);
    swr(9'h000, 32'h0, 2'b10);
    srd(9'h120, d); chk("R8 single ch2 event ignored", d, 32'h0);
    swr(9'h11C, 32'h8000_0000, 2'b10);
    chk("R8 single irq stays low", {31'b0, s_irq}, 32'h0);
    swr(9'h000, 32'h0, 2'b01);
    srd(9'h120, d); chk("R8 single ch1 event", d, 32'h1);
    chk("R8 single irq", {31'b0, s_irq}, 32'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule